// File: doc/BRIEF.md
# Receive Cell Packer with Clock-Crossing Cell Buffer

This block sits on the receive side of a cell reassembly engine, directly behind the physical-layer device. It takes a byte stream in the PHY clock domain. A start-of-cell strobe marks the first byte of each 52-byte cell. The block packs the bytes into 32-bit words, so each cell becomes 13 words. Cells whose four header bytes match the idle pattern are thrown away.

Surviving cells are written into a dual-clock buffer that holds a fixed number of whole cells. Flow control across the clock boundary works per cell, not per word. A cell becomes visible to the system clock domain only after all of its words are stored. The words are then offered one at a time to the downstream header and channel processor, through a valid/ready handshake. The first and last word of each cell are flagged.

If the buffer has no free cell slot when a data cell's header completes, the whole cell is dropped and a wrapping drop counter advances. A start-of-cell strobe that arrives in the middle of a cell abandons the partial cell.

Top module: `rx_cell_packer`

## Requirements
- R1: Each group of four consecutive cell bytes forms one 32-bit word with the earliest byte in bits 31:24. A 52-byte cell yields 13 words in arrival order.
- R2: A cell whose bytes 0..3 are 0x00, 0x00, 0x00, 0x01 is never presented on the read side and does not change the drop counter.
- R3: A non-idle cell whose header completes while the buffer already holds its full count of cells is dropped in full. The drop counter rises by exactly one. A slot freed by reading can be reused by a later cell.
- R4: With the default depth, 32 complete cells are held without loss while the reader is stalled. All of them are later delivered.
- R5: A start-of-cell strobe that arrives before byte 51 of the current cell discards that partial cell. The strobed byte becomes byte 0 of a new cell.
- R6: `cell_first_o` is high only on word 0 of a cell and `cell_last_o` is high only on word 12. After a last word is accepted, the next valid word is a first word.
- R7: While `cell_valid_o` is high and `cell_ready_i` is low, the data word and the markers stay unchanged.
- R8: After reset, `cell_valid_o` is low and the drop counter is zero.
- R9: Bytes with `phy_valid_i` low are ignored, even if the strobe is high. Valid bytes that arrive after a cell has ended and before the next strobe are ignored.
- R10: Cells are delivered in the system clock domain in the order they arrived. The cell pointers that cross the boundary change by at most one bit per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| phy_clk_i | input | 1 | PHY byte clock |
| sys_clk_i | input | 1 | System bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| phy_data_i | input | 8 | Received byte |
| phy_valid_i | input | 1 | Byte qualifier |
| phy_soc_i | input | 1 | Start-of-cell strobe, on byte 0 |
| ovf_count_o | output | 16 | Count of cells dropped for lack of space, in the PHY clock domain |
| cell_data_o | output | 32 | Word offered to the downstream processor |
| cell_valid_o | output | 1 | Word available |
| cell_first_o | output | 1 | Word 0 of a cell |
| cell_last_o | output | 1 | Last word of a cell |
| cell_ready_i | input | 1 | Downstream accepts the word |

## Verification
The idle-pattern decision and the buffer-full admission decision are both made on the same clock: the one that completes the fourth header byte. Their outcomes must not interfere. The bench fills the buffer with 32 cells while the reader is stalled. It then sends one data cell and one idle cell back to back. The drop counter must read exactly one: the data cell is counted and the idle cell is silently discarded. The bench then frees one slot by reading, sends a new cell, and expects it to come out after the 31 older cells.

// File: rtl/rxcp_pkg.sv
package rxcp_pkg;
  localparam logic [31:0] RXCP_IDLE_HDR = 32'h0000_0001;

  typedef struct packed {
    logic        we;
    logic        commit;
    logic [31:0] data;
  } rxcp_wr_t;
endpackage

// File: rtl/rxcp_sync.sv
module rxcp_sync #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/rxcp_packer.sv
module rxcp_packer
  import rxcp_pkg::*;
#(
  parameter int unsigned CELL_WORDS = 13,
  parameter int unsigned CNT_W      = 16,
  localparam int unsigned CELL_BYTES = CELL_WORDS * 4,
  localparam int unsigned BC_W       = $clog2(CELL_BYTES),
  localparam int unsigned IDX_W      = $clog2(CELL_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       data_i,
  input  logic             valid_i,
  input  logic             soc_i,
  input  logic             full_i,
  output rxcp_wr_t         wr_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [CNT_W-1:0] ovf_cnt_o
);
  logic            in_cell_q, keep_q;
  logic [BC_W-1:0] byte_cnt_q;
  logic [23:0]     shift_q;
  logic [CNT_W-1:0] ovf_q;

  logic        live, word_done, at_hdr, at_end, is_idle, admit, keep_now;
  logic [31:0] word;

  always_comb begin
    live      = valid_i && in_cell_q && !soc_i;
    word      = {shift_q, data_i};
    word_done = live && (byte_cnt_q[1:0] == 2'd3);
    at_hdr    = live && (byte_cnt_q == BC_W'(3));
    at_end    = live && (byte_cnt_q == BC_W'(CELL_BYTES - 1));
    is_idle   = (word == RXCP_IDLE_HDR);
    // idle and full are judged together on the fourth header byte
    admit     = at_hdr && !is_idle && !full_i;
    keep_now  = at_hdr ? admit : keep_q;
    wr_o.we     = word_done && keep_now;
    wr_o.commit = at_end && keep_q;
    wr_o.data   = word;
  end

  assign wr_idx_o  = byte_cnt_q[BC_W-1:2];
  assign ovf_cnt_o = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_cell_q  <= 1'b0;
      keep_q     <= 1'b0;
      byte_cnt_q <= '0;
      shift_q    <= '0;
      ovf_q      <= '0;
    end else if (valid_i) begin
      shift_q <= {shift_q[15:0], data_i};
      if (soc_i) begin
        in_cell_q  <= 1'b1;
        keep_q     <= 1'b0;
        byte_cnt_q <= BC_W'(1);
      end else if (in_cell_q) begin
        byte_cnt_q <= byte_cnt_q + BC_W'(1);
        if (at_hdr) keep_q <= admit;
        if (at_hdr && !is_idle && full_i) ovf_q <= ovf_q + CNT_W'(1);
        if (at_end) in_cell_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rxcp_cell_fifo.sv
module rxcp_cell_fifo
  import rxcp_pkg::*;
#(
  parameter int unsigned CELL_WORDS  = 13,
  parameter int unsigned DEPTH_CELLS = 32,
  localparam int unsigned PTR_W  = $clog2(DEPTH_CELLS) + 1,
  localparam int unsigned SLOT_W = PTR_W - 1,
  localparam int unsigned IDX_W  = $clog2(CELL_WORDS),
  localparam int unsigned WORDS  = DEPTH_CELLS * CELL_WORDS,
  localparam int unsigned ADDR_W = $clog2(WORDS)
) (
  input  logic             wclk_i,
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  rxcp_wr_t         wr_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  output logic             full_o,
  output logic [31:0]      rd_data_o,
  output logic             rd_valid_o,
  output logic             rd_first_o,
  output logic             rd_last_o,
  input  logic             rd_ready_i,
  output logic [PTR_W-1:0] wgray_o,
  output logic [PTR_W-1:0] rgray_o
);
  function automatic logic [PTR_W-1:0] b2g(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] g2b(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [31:0] mem [WORDS];

  // write domain
  logic [PTR_W-1:0] wbin_q, wgray_q, rgray_w, rbin_w, wnext;
  logic [ADDR_W-1:0] waddr;

  rxcp_sync #(.W(PTR_W)) u_sync_r2w (
    .clk_i (wclk_i), .rst_ni(rst_ni), .d_i(rgray_q), .q_o(rgray_w)
  );

  always_comb begin
    rbin_w = g2b(rgray_w);
    wnext  = wbin_q + PTR_W'(1);
    full_o = (wbin_q - rbin_w) == PTR_W'(DEPTH_CELLS);
    waddr  = ADDR_W'(wbin_q[SLOT_W-1:0]) * ADDR_W'(CELL_WORDS) + ADDR_W'(wr_idx_i);
  end

  always_ff @(posedge wclk_i) begin
    if (wr_i.we) mem[waddr] <= wr_i.data;
  end

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (wr_i.commit) begin
      wbin_q  <= wnext;
      wgray_q <= b2g(wnext);
    end
  end

  // read domain
  logic [PTR_W-1:0] rbin_q, rgray_q, wgray_r, wbin_r, rnext;
  logic [IDX_W-1:0] word_q;
  logic [ADDR_W-1:0] raddr;
  logic             cell_end;

  rxcp_sync #(.W(PTR_W)) u_sync_w2r (
    .clk_i (rclk_i), .rst_ni(rst_ni), .d_i(wgray_q), .q_o(wgray_r)
  );

  always_comb begin
    wbin_r     = g2b(wgray_r);
    rnext      = rbin_q + PTR_W'(1);
    rd_valid_o = (rbin_q != wbin_r);
    raddr      = ADDR_W'(rbin_q[SLOT_W-1:0]) * ADDR_W'(CELL_WORDS) + ADDR_W'(word_q);
    rd_data_o  = mem[raddr];
    cell_end   = (word_q == IDX_W'(CELL_WORDS - 1));
    rd_first_o = (word_q == '0);
    rd_last_o  = cell_end;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      word_q  <= '0;
    end else if (rd_valid_o && rd_ready_i) begin
      if (cell_end) begin
        word_q  <= '0;
        rbin_q  <= rnext;
        rgray_q <= b2g(rnext);
      end else begin
        word_q <= word_q + IDX_W'(1);
      end
    end
  end

  assign wgray_o = wgray_q;
  assign rgray_o = rgray_q;
endmodule

// File: rtl/rx_cell_packer.sv
module rx_cell_packer
  import rxcp_pkg::*;
#(
  parameter int unsigned CELL_WORDS  = 13,
  parameter int unsigned DEPTH_CELLS = 32,
  parameter int unsigned CNT_W       = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH_CELLS) + 1,
  localparam int unsigned IDX_W = $clog2(CELL_WORDS)
) (
  input  logic             phy_clk_i,
  input  logic             sys_clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       phy_data_i,
  input  logic             phy_valid_i,
  input  logic             phy_soc_i,
  output logic [CNT_W-1:0] ovf_count_o,
  output logic [31:0]      cell_data_o,
  output logic             cell_valid_o,
  output logic             cell_first_o,
  output logic             cell_last_o,
  input  logic             cell_ready_i
);
  rxcp_wr_t         wr;
  logic [IDX_W-1:0] wr_idx;
  logic             full;
  logic [PTR_W-1:0] wgray, rgray;

  rxcp_packer #(.CELL_WORDS(CELL_WORDS), .CNT_W(CNT_W)) u_packer (
    .clk_i    (phy_clk_i),
    .rst_ni   (rst_ni),
    .data_i   (phy_data_i),
    .valid_i  (phy_valid_i),
    .soc_i    (phy_soc_i),
    .full_i   (full),
    .wr_o     (wr),
    .wr_idx_o (wr_idx),
    .ovf_cnt_o(ovf_count_o)
  );

  rxcp_cell_fifo #(.CELL_WORDS(CELL_WORDS), .DEPTH_CELLS(DEPTH_CELLS)) u_fifo (
    .wclk_i    (phy_clk_i),
    .rclk_i    (sys_clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr),
    .wr_idx_i  (wr_idx),
    .full_o    (full),
    .rd_data_o (cell_data_o),
    .rd_valid_o(cell_valid_o),
    .rd_first_o(cell_first_o),
    .rd_last_o (cell_last_o),
    .rd_ready_i(cell_ready_i),
    .wgray_o   (wgray),
    .rgray_o   (rgray)
  );
endmodule

// File: rtl/rxcp_checker.sv
module rxcp_checker #(
  parameter int unsigned PTR_W = 6,
  parameter int unsigned CNT_W = 16
) (
  input logic             phy_clk_i,
  input logic             sys_clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] ovf_count_o,
  input logic [31:0]      cell_data_o,
  input logic             cell_valid_o,
  input logic             cell_first_o,
  input logic             cell_last_o,
  input logic             cell_ready_i,
  input logic [PTR_W-1:0] wgray,
  input logic [PTR_W-1:0] rgray
);
  AST_MARKERS_EXCL: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    cell_valid_o |-> $onehot0({cell_first_o, cell_last_o})); // R6

  AST_FIRST_AFTER_LAST: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    cell_valid_o && cell_ready_i && cell_last_o |=> !cell_valid_o || cell_first_o); // R6

  AST_STALL_HOLD: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    cell_valid_o && !cell_ready_i |=> cell_valid_o && $stable(cell_data_o)
      && $stable(cell_first_o) && $stable(cell_last_o)); // R7

  AST_OVF_STEP: assert property (@(posedge phy_clk_i) disable iff (!rst_ni)
    ovf_count_o != $past(ovf_count_o) |-> ovf_count_o == $past(ovf_count_o) + CNT_W'(1)); // R3

  AST_WGRAY_STEP: assert property (@(posedge phy_clk_i) disable iff (!rst_ni)
    $countones(wgray ^ $past(wgray)) <= 1); // R10

  AST_RGRAY_STEP: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    $countones(rgray ^ $past(rgray)) <= 1); // R10
endmodule

bind rx_cell_packer rxcp_checker #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_chk (
  .phy_clk_i   (phy_clk_i),
  .sys_clk_i   (sys_clk_i),
  .rst_ni      (rst_ni),
  .ovf_count_o (ovf_count_o),
  .cell_data_o (cell_data_o),
  .cell_valid_o(cell_valid_o),
  .cell_first_o(cell_first_o),
  .cell_last_o (cell_last_o),
  .cell_ready_i(cell_ready_i),
  .wgray       (wgray),
  .rgray       (rgray)
);

// File: tb/rx_cell_packer_tb_top.sv
`timescale 1ns/1ps
module rx_cell_packer_tb_top;
  logic        phy_clk = 0, sys_clk = 0, rst_n = 0;
  logic [7:0]  phy_data = 0;
  logic        phy_valid = 0, phy_soc = 0, ready = 0;
  logic [15:0] ovf;
  logic [31:0] cdata;
  logic        cvalid, cfirst, clast;
  int          n_chk = 0, n_fail = 0;

  always #2.5 sys_clk = ~sys_clk;
  always #3.5 phy_clk = ~phy_clk;

  rx_cell_packer dut_i (
    .phy_clk_i(phy_clk), .sys_clk_i(sys_clk), .rst_ni(rst_n),
    .phy_data_i(phy_data), .phy_valid_i(phy_valid), .phy_soc_i(phy_soc),
    .ovf_count_o(ovf), .cell_data_o(cdata), .cell_valid_o(cvalid),
    .cell_first_o(cfirst), .cell_last_o(clast), .cell_ready_i(ready)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cbyte(input logic [7:0] id, input int k);
    case (k)
      0: return id;
      1: return 8'hA0;
      2: return 8'h00;
      3: return 8'h10;
      default: return id + 8'(k);
    endcase
  endfunction

  function automatic logic [31:0] eword(input logic [7:0] id, input int w);
    return {cbyte(id, 4*w), cbyte(id, 4*w+1), cbyte(id, 4*w+2), cbyte(id, 4*w+3)};
  endfunction

  task automatic put_byte(input logic [7:0] d, input bit soc);
    @(negedge phy_clk);
    phy_data = d; phy_valid = 1; phy_soc = soc;
  endtask

  task automatic phy_idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge phy_clk);
      phy_valid = 0; phy_soc = 0; phy_data = 8'h5A;
    end
  endtask

  task automatic send_cell(input logic [7:0] id, input bit idle, input int nbytes, input bit gaps);
    for (int k = 0; k < nbytes; k++) begin
      if (gaps && (k % 5 == 2)) phy_idle(1);
      if (idle) put_byte((k < 3) ? 8'h00 : (k == 3) ? 8'h01 : 8'h6A, k == 0);
      else      put_byte(cbyte(id, k), k == 0);
    end
  endtask

  task automatic read_cell(input logic [7:0] id, input string req);
    for (int w = 0; w < 13; w++) begin
      int t = 0;
      @(negedge sys_clk);
      while (!cvalid && t < 400) begin @(negedge sys_clk); t++; end
      chk(cvalid, {req, " valid"}, 32'(cvalid), 1);
      chk(cdata == eword(id, w), {req, " data"}, cdata, eword(id, w));
      chk(cfirst == (w == 0) && clast == (w == 12), {req, " R6 markers"},
          {30'b0, cfirst, clast}, {30'b0, w == 0, w == 12});
      ready = 1;
      @(posedge sys_clk);
      #1 ready = 0;
    end
  endtask

  task automatic expect_empty(input string req);
    repeat (60) @(negedge sys_clk);
    chk(!cvalid, {req, " empty"}, 32'(cvalid), 0);
  endtask

  task automatic t_reset;
    @(negedge sys_clk);
    chk(!cvalid, "R8 valid after reset", 32'(cvalid), 0);
    chk(ovf == 0, "R8 counter after reset", 32'(ovf), 0);
  endtask

  task automatic t_basic;
    send_cell(8'h01, 0, 52, 0);
    send_cell(8'h02, 0, 52, 0);
    send_cell(8'h03, 0, 52, 0);
    phy_idle(2);
    read_cell(8'h01, "R1 R10 cell1");
    read_cell(8'h02, "R1 R10 cell2");
    read_cell(8'h03, "R1 R10 cell3");
    expect_empty("R10");
  endtask

  task automatic t_idle;
    send_cell(8'h04, 0, 52, 0);
    send_cell(8'h00, 1, 52, 0);
    send_cell(8'h05, 0, 52, 0);
    phy_idle(2);
    read_cell(8'h04, "R2 before idle");
    read_cell(8'h05, "R2 after idle");
    expect_empty("R2");
    chk(ovf == 0, "R2 counter", 32'(ovf), 0);
  endtask

  task automatic t_abort;
    send_cell(8'h06, 0, 20, 0);
    send_cell(8'h07, 0, 52, 0);
    phy_idle(2);
    read_cell(8'h07, "R5 restarted cell");
    expect_empty("R5");
  endtask

  task automatic t_ignore;
    send_cell(8'h08, 0, 52, 1);
    for (int k = 0; k < 30; k++) put_byte(8'(k), 0);
    for (int k = 0; k < 6; k++) begin
      @(negedge phy_clk);
      phy_valid = 0; phy_soc = 1; phy_data = 8'h33;
    end
    phy_idle(2);
    read_cell(8'h08, "R9 gapped cell");
    expect_empty("R9");
  endtask

  task automatic t_stall;
    int t = 0;
    send_cell(8'h09, 0, 52, 0);
    phy_idle(2);
    @(negedge sys_clk);
    while (!cvalid && t < 400) begin @(negedge sys_clk); t++; end
    for (int i = 0; i < 8; i++) begin
      chk(cvalid && cdata == eword(8'h09, 0) && cfirst, "R7 hold", cdata, eword(8'h09, 0));
      @(negedge sys_clk);
    end
    read_cell(8'h09, "R7 after stall");
  endtask

  task automatic t_full;
    for (int c = 0; c < 32; c++) send_cell(8'(8'h20 + c), 0, 52, 0);
    phy_idle(30);
    send_cell(8'h70, 0, 52, 0);
    phy_idle(2);
    chk(ovf == 1, "R3 drop count", 32'(ovf), 1);
    send_cell(8'h00, 1, 52, 0);
    phy_idle(2);
    chk(ovf == 1, "R2 R3 idle while full", 32'(ovf), 1);
    read_cell(8'h20, "R4 oldest");
    repeat (30) @(negedge sys_clk);
    send_cell(8'h71, 0, 52, 0);
    phy_idle(2);
    chk(ovf == 1, "R3 reuse accepted", 32'(ovf), 1);
    for (int c = 1; c < 32; c++) read_cell(8'(8'h20 + c), "R4 stored cell");
    read_cell(8'h71, "R3 reused slot");
    expect_empty("R4");
  endtask

  initial begin
    repeat (5) @(negedge sys_clk);
    rst_n = 1;
    repeat (3) @(negedge sys_clk);
    t_reset;
    t_basic;
    t_idle;
    t_abort;
    t_ignore;
    t_stall;
    t_full;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge sys_clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule